// File: doc/BRIEF.md
# Direct-Mapped Address Translation Buffer

This block translates 32-bit virtual addresses into physical addresses on 8 KB pages. It holds a single-way table of 64 entries. Each entry has two words. The match word carries the virtual page tag and a valid flag. The translate word carries the physical page and a set of per-privilege permission bits.

One instance serves the instruction fetch path and another serves the load/store path. The parameter `IS_CODE` picks which permission decoder is built. Software fills entries through an indexed write port. Each lookup request produces a registered response one cycle later. The response carries a status, the physical address and the rights that were granted. Refill from page tables and exception vectoring belong to the surrounding logic.

Top module: `xtlb_lookup`

## Requirements
- R1: Bits [12:0] of an address are the page offset and bits [31:13] are the virtual page number. On a hit, `rsp_paddr_o` is translate-word bits [31:13] joined with the request's offset bits [12:0].
- R2: The table is direct-mapped. The entry used is the one indexed by virtual page number bits [5:0]. The match word stores the page tag in bits [31:13] and the valid flag in bit 0.
- R3: If the stored tag differs from the requested virtual page number, the status is no-match (`rsp_status_o` = 1).
- R4: If the tag agrees but the valid flag is clear, the status is invalid (`rsp_status_o` = 2).
- R5: With `IS_CODE`=0, the translate word grants rights from these bits: user read at bit 6, user write at bit 7, supervisor read at bit 8, supervisor write at bit 9. `req_super_i` picks the privilege. `rsp_rights_o` is {exec, write, read} (bit 2 down to bit 0).
- R6: With `IS_CODE`=1, the translate word grants supervisor execute at bit 6 and user execute at bit 7. A fetch without execute right returns bad-address (`rsp_status_o` = 3).
- R7: On the data side, a store without write right or a load without read right returns bad-address (status 3). Otherwise a valid tag hit returns hit (status 0).
- R8: `rsp_valid_o` rises exactly one cycle after `req_i` and is low in a cycle that follows no request. For any status other than hit, `rsp_paddr_o` and `rsp_rights_o` are zero.
- R9: Reset clears every entry: tag, valid flag and translate word all become zero.
- R10: When `wr_sel_i`=0 a write loads the match word, and when `wr_sel_i`=1 it loads the translate word. The write is seen by the lookup one cycle later. A lookup in the same cycle as the write sees the old contents.
- R11: With `IS_CODE`=1, `req_write_i` has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Entry write strobe |
| wr_idx_i | input | 6 | Entry index to write |
| wr_sel_i | input | 1 | 0: match word, 1: translate word |
| wr_data_i | input | 32 | Word to write |
| req_i | input | 1 | Lookup request |
| req_vaddr_i | input | 32 | Virtual address |
| req_write_i | input | 1 | Store (1) or load (0); ignored on the code side |
| req_super_i | input | 1 | Supervisor privilege |
| rsp_valid_o | output | 1 | Response strobe, one cycle after the request |
| rsp_status_o | output | 2 | 0 hit, 1 no-match, 2 invalid, 3 bad-address |
| rsp_paddr_o | output | 32 | Physical address on hit, else zero |
| rsp_rights_o | output | 3 | {exec, write, read} granted on hit, else zero |

## Verification
The bench builds two copies with the default 64 entries and 13-bit pages: one with `IS_CODE`=0 and one with `IS_CODE`=1. Both copies receive the same writes and requests, so every vector exercises the read/write decoder and the execute decoder side by side. Index 1 is targeted by two different page numbers (0x1 and 0x41) to reach tag aliasing. Index 0x21, which holds only reset contents, gives a no-match on an entry that was never written. Entry 0 after reset gives invalid for page number 0.

// File: rtl/xtlb_pkg.sv
package xtlb_pkg;
  typedef enum logic [1:0] {
    ST_HIT      = 2'd0,
    ST_NOMATCH  = 2'd1,
    ST_INVALID  = 2'd2,
    ST_BADADDR  = 2'd3
  } xtlb_status_e;

  typedef struct packed {
    logic x;
    logic w;
    logic r;
  } xtlb_rights_t;

  localparam int PERM_LSB = 6;
  localparam int PERM_W   = 4;
endpackage

// File: rtl/xtlb_array.sv
module xtlb_array
  import xtlb_pkg::*;
#(
  parameter int ENTRIES   = 64,
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 13,
  localparam int IDX_W    = $clog2(ENTRIES),
  localparam int TAG_W    = ADDR_W - PAGE_BITS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic              wr_sel_i,
  input  logic [ADDR_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [TAG_W-1:0]  rd_tag_o,
  output logic              rd_valid_o,
  output logic [TAG_W-1:0]  rd_ppn_o,
  output logic [PERM_W-1:0] rd_perm_o
);
  logic [TAG_W-1:0]  tag_q  [ENTRIES];
  logic              vld_q  [ENTRIES];
  logic [TAG_W-1:0]  ppn_q  [ENTRIES];
  logic [PERM_W-1:0] perm_q [ENTRIES];

  logic unused_wr_bits;
  assign unused_wr_bits = ^{wr_data_i[PAGE_BITS-1:PERM_LSB+PERM_W], wr_data_i[PERM_LSB-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) begin
        tag_q[i]  <= '0;
        vld_q[i]  <= 1'b0;
        ppn_q[i]  <= '0;
        perm_q[i] <= '0;
      end
    end else if (wr_en_i) begin
      if (!wr_sel_i) begin
        tag_q[wr_idx_i] <= wr_data_i[ADDR_W-1:PAGE_BITS];
        vld_q[wr_idx_i] <= wr_data_i[0];
      end else begin
        ppn_q[wr_idx_i]  <= wr_data_i[ADDR_W-1:PAGE_BITS];
        perm_q[wr_idx_i] <= wr_data_i[PERM_LSB+PERM_W-1:PERM_LSB];
      end
    end
  end

  assign rd_tag_o   = tag_q[rd_idx_i];
  assign rd_valid_o = vld_q[rd_idx_i];
  assign rd_ppn_o   = ppn_q[rd_idx_i];
  assign rd_perm_o  = perm_q[rd_idx_i];

  AST_VALID_FOLLOWS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_sel_i) |=> (vld_q[$past(wr_idx_i)] == $past(wr_data_i[0]))); // R10
endmodule

// File: rtl/xtlb_perm.sv
module xtlb_perm
  import xtlb_pkg::*;
#(
  parameter bit IS_CODE = 1'b0
) (
  input  logic [PERM_W-1:0] perm_i,
  input  logic              super_i,
  input  logic              write_i,
  output xtlb_rights_t      rights_o,
  output logic              allow_o
);
  // perm_i[k] is translate-word bit PERM_LSB+k
  generate
    if (IS_CODE) begin : g_code
      logic unused_code;
      assign unused_code = ^{write_i, perm_i[3:2]};
      always_comb begin
        rights_o   = '0;
        rights_o.x = super_i ? perm_i[0] : perm_i[1];
        allow_o    = rights_o.x;
      end
    end else begin : g_data
      always_comb begin
        rights_o   = '0;
        rights_o.r = super_i ? perm_i[2] : perm_i[0];
        rights_o.w = super_i ? perm_i[3] : perm_i[1];
        allow_o    = write_i ? rights_o.w : rights_o.r;
      end
    end
  endgenerate
endmodule

// File: rtl/xtlb_lookup.sv
module xtlb_lookup
  import xtlb_pkg::*;
#(
  parameter bit IS_CODE   = 1'b0,
  parameter int ENTRIES   = 64,
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 13,
  localparam int IDX_W    = $clog2(ENTRIES),
  localparam int TAG_W    = ADDR_W - PAGE_BITS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic              wr_sel_i,
  input  logic [ADDR_W-1:0] wr_data_i,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] req_vaddr_i,
  input  logic              req_write_i,
  input  logic              req_super_i,
  output logic              rsp_valid_o,
  output logic [1:0]        rsp_status_o,
  output logic [ADDR_W-1:0] rsp_paddr_o,
  output logic [2:0]        rsp_rights_o
);
  logic [TAG_W-1:0]  vpn;
  logic [TAG_W-1:0]  ent_tag, ent_ppn;
  logic              ent_vld;
  logic [PERM_W-1:0] ent_perm;
  xtlb_rights_t      granted;
  logic              allow;
  xtlb_status_e      status_d;

  assign vpn = req_vaddr_i[ADDR_W-1:PAGE_BITS];

  xtlb_array #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_array (
    .clk_i, .rst_ni, .wr_en_i, .wr_idx_i, .wr_sel_i, .wr_data_i,
    .rd_idx_i(vpn[IDX_W-1:0]), .rd_tag_o(ent_tag), .rd_valid_o(ent_vld),
    .rd_ppn_o(ent_ppn), .rd_perm_o(ent_perm)
  );

  xtlb_perm #(.IS_CODE(IS_CODE)) u_perm (
    .perm_i(ent_perm), .super_i(req_super_i), .write_i(req_write_i),
    .rights_o(granted), .allow_o(allow)
  );

  // tag check precedes valid, which precedes rights
  always_comb begin
    if (ent_tag != vpn)  status_d = ST_NOMATCH;
    else if (!ent_vld)   status_d = ST_INVALID;
    else if (!allow)     status_d = ST_BADADDR;
    else                 status_d = ST_HIT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o  <= 1'b0;
      rsp_status_o <= ST_HIT;
      rsp_paddr_o  <= '0;
      rsp_rights_o <= '0;
    end else begin
      rsp_valid_o <= req_i;
      if (req_i) begin
        rsp_status_o <= status_d;
        if (status_d == ST_HIT) begin
          rsp_paddr_o  <= {ent_ppn, req_vaddr_i[PAGE_BITS-1:0]};
          rsp_rights_o <= granted;
        end else begin
          rsp_paddr_o  <= '0;
          rsp_rights_o <= '0;
        end
      end
    end
  end

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> rsp_valid_o); // R8
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !rsp_valid_o); // R8
  AST_MISS_ZEROED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_status_o != ST_HIT) |-> (rsp_paddr_o == '0 && rsp_rights_o == '0)); // R8
  AST_OFFSET_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> (rsp_status_o != ST_HIT || rsp_paddr_o[PAGE_BITS-1:0] == $past(req_vaddr_i[PAGE_BITS-1:0]))); // R1

  generate
    if (IS_CODE) begin : g_ast_code
      AST_FETCH_NEEDS_EXEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_i |=> (rsp_status_o != ST_HIT || rsp_rights_o[2])); // R6
    end else begin : g_ast_data
      AST_STORE_NEEDS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && req_write_i) |=> (rsp_status_o != ST_HIT || rsp_rights_o[1])); // R7
      AST_LOAD_NEEDS_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && !req_write_i) |=> (rsp_status_o != ST_HIT || rsp_rights_o[0])); // R7
    end
  endgenerate
endmodule

// File: tb/sim_xtlb_lookup.sv
`timescale 1ns/1ps
module sim_xtlb_lookup;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_idx = '0;
  logic        wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic        req = 1'b0;
  logic [31:0] vaddr = '0;
  logic        req_wr = 1'b0;
  logic        req_sup = 1'b0;
  logic        d_vld, c_vld;
  logic [1:0]  d_st, c_st;
  logic [31:0] d_pa, c_pa;
  logic [2:0]  d_rt, c_rt;
  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  xtlb_lookup #(.IS_CODE(1'b0)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .req_i(req), .req_vaddr_i(vaddr), .req_write_i(req_wr),
    .req_super_i(req_sup), .rsp_valid_o(d_vld), .rsp_status_o(d_st),
    .rsp_paddr_o(d_pa), .rsp_rights_o(d_rt));

  xtlb_lookup #(.IS_CODE(1'b1)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .req_i(req), .req_vaddr_i(vaddr), .req_write_i(req_wr),
    .req_super_i(req_sup), .rsp_valid_o(c_vld), .rsp_status_o(c_st),
    .rsp_paddr_o(c_pa), .rsp_rights_o(c_rt));

  typedef struct packed {
    logic [31:0] va;
    logic        wr;
    logic        sup;
    logic [1:0]  dst;
    logic [31:0] dpa;
    logic [2:0]  drt;
    logic [1:0]  cst;
    logic [31:0] cpa;
    logic [2:0]  crt;
  } vec_t;

  // status 0 hit, 1 no-match, 2 invalid, 3 bad-address; rights {x,w,r}
  localparam vec_t VECS [10] = '{
    '{32'h0000_2ABC, 1'b0, 1'b0, 2'd0, 32'hABCD_EABC, 3'b011, 2'd0, 32'hABCD_EABC, 3'b100},
    '{32'h0000_2ABC, 1'b1, 1'b1, 2'd0, 32'hABCD_EABC, 3'b011, 2'd0, 32'hABCD_EABC, 3'b100},
    '{32'h0008_4123, 1'b0, 1'b0, 2'd0, 32'h1234_6123, 3'b001, 2'd3, 32'h0, 3'b000},
    '{32'h0008_4123, 1'b1, 1'b0, 2'd3, 32'h0, 3'b000, 2'd3, 32'h0, 3'b000},
    '{32'h0008_4123, 1'b0, 1'b1, 2'd3, 32'h0, 3'b000, 2'd0, 32'h1234_6123, 3'b100},
    '{32'h0000_6000, 1'b0, 1'b1, 2'd2, 32'h0, 3'b000, 2'd2, 32'h0, 3'b000},
    '{32'h0000_8FFF, 1'b0, 1'b0, 2'd3, 32'h0, 3'b000, 2'd0, 32'h5555_4FFF, 3'b100},
    '{32'h0000_8FFF, 1'b1, 1'b0, 2'd0, 32'h5555_4FFF, 3'b010, 2'd0, 32'h5555_4FFF, 3'b100},
    '{32'h0404_2000, 1'b0, 1'b1, 2'd1, 32'h0, 3'b000, 2'd1, 32'h0, 3'b000},
    '{32'h0008_2000, 1'b0, 1'b1, 2'd1, 32'h0, 3'b000, 2'd1, 32'h0, 3'b000}
  };

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] idx, input logic sel, input logic [31:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // drives a request; outputs sampled one negedge later
  task automatic look(input logic [31:0] va, input logic w, input logic s);
    @(negedge clk);
    req = 1'b1; vaddr = va; req_wr = w; req_sup = s;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic chk_both(input string tag, input logic [1:0] dst, input logic [31:0] dpa,
                          input logic [2:0] drt, input logic [1:0] cst, input logic [31:0] cpa,
                          input logic [2:0] crt);
    chk({tag, " data valid"}, {31'b0, d_vld}, 32'd1);
    chk({tag, " data status"}, {30'b0, d_st}, {30'b0, dst});
    chk({tag, " data paddr"}, d_pa, dpa);
    chk({tag, " data rights"}, {29'b0, d_rt}, {29'b0, drt});
    chk({tag, " code valid"}, {31'b0, c_vld}, 32'd1);
    chk({tag, " code status"}, {30'b0, c_st}, {30'b0, cst});
    chk({tag, " code paddr"}, c_pa, cpa);
    chk({tag, " code rights"}, {29'b0, c_rt}, {29'b0, crt});
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 reset rsp_valid data", {31'b0, d_vld}, 32'd0);
    chk("R8 reset rsp_valid code", {31'b0, c_vld}, 32'd0);
    rst_n = 1'b1;

    // R9 R4: entry 0 holds tag 0 with valid clear
    look(32'h0000_0100, 1'b0, 1'b1);
    chk_both("R9 R4 reset entry0", 2'd2, 32'h0, 3'b0, 2'd2, 32'h0, 3'b0);
    // R3: entry 0x20 tag 0 vs page 0x20
    look(32'h0004_0000, 1'b0, 1'b0);
    chk_both("R3 reset tag miss", 2'd1, 32'h0, 3'b0, 2'd1, 32'h0, 3'b0);

    // R2 R10 table fill
    wr(6'd1, 1'b0, 32'h0000_2001);
    wr(6'd1, 1'b1, 32'hABCD_E3C0);
    wr(6'd2, 1'b0, 32'h0008_4001);
    wr(6'd2, 1'b1, 32'h1234_6040);
    wr(6'd3, 1'b0, 32'h0000_6000);
    wr(6'd4, 1'b0, 32'h0000_8001);
    wr(6'd4, 1'b1, 32'h5555_4280);

    // R1 R2 R3 R4 R5 R6 R7 R11 vector walk
    for (int i = 0; i < 10; i++) begin
      look(VECS[i].va, VECS[i].wr, VECS[i].sup);
      chk_both($sformatf("R5 R6 R7 R11 vec%0d", i), VECS[i].dst, VECS[i].dpa, VECS[i].drt,
               VECS[i].cst, VECS[i].cpa, VECS[i].crt);
    end

    // R8 no request -> no response
    @(negedge clk);
    chk("R8 idle data", {31'b0, d_vld}, 32'd0);
    chk("R8 idle code", {31'b0, c_vld}, 32'd0);

    // R10 write then lookup next cycle
    wr(6'd3, 1'b0, 32'h0000_6001);
    wr(6'd3, 1'b1, 32'hFFFF_E3C0);
    look(32'h0000_7FFF, 1'b1, 1'b1);
    chk_both("R10 R1 rewrite", 2'd0, 32'hFFFF_FFFF, 3'b011, 2'd0, 32'hFFFF_FFFF, 3'b100);

    // R10 same-cycle write sees old contents
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 6'd3; wr_sel = 1'b0; wr_data = 32'h0000_6000;
    req = 1'b1; vaddr = 32'h0000_7FFF; req_wr = 1'b0; req_sup = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; req = 1'b0;
    chk_both("R10 same cycle", 2'd0, 32'hFFFF_FFFF, 3'b011, 2'd0, 32'hFFFF_FFFF, 3'b100);
    look(32'h0000_7FFF, 1'b0, 1'b1);
    chk_both("R10 R4 after clear", 2'd2, 32'h0, 3'b0, 2'd2, 32'h0, 3'b0);

    // R9 reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R9 R8 reset valid", {31'b0, d_vld}, 32'd0);
    rst_n = 1'b1;
    look(32'h0000_2ABC, 1'b0, 1'b1);
    chk_both("R9 entry1 cleared", 2'd1, 32'h0, 3'b0, 2'd1, 32'h0, 3'b0);
    look(32'h0000_0010, 1'b0, 1'b1);
    chk_both("R9 entry0 invalid", 2'd2, 32'h0, 3'b0, 2'd2, 32'h0, 3'b0);

    finish_run();
  end
endmodule